// File: doc/BRIEF.md
# Sleep and Idle Power-State Controller

This block decides which clocks run in a small microcontroller. The CPU issues a power-save command that carries a one-bit mode operand. The controller then moves into one of two low-power states. Idle stops only the CPU clock. Sleep also shuts down the primary oscillator and the peripheral clock, pulses a clear to the watchdog, and suspends the clock-fail monitor.

An enabled interrupt, a watchdog time-out or a reset brings the core back. After Sleep, the oscillator must settle before the CPU clock returns. A counter holds the CPU clock off for `SETTLE_CYC` cycles, and the clock source that was in use at Sleep entry is kept. Outside the low-power states, software may pick a new clock source, but only while the configuration lock is low.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A power-save command is a one-cycle `save_req` in the run state. `save_mode` = 0 selects Sleep and `save_mode` = 1 selects Idle. The new state is visible in the cycle after the command edge.
- R2: In Sleep, `cpu_clk_en`, `per_clk_en` and `posc_en` are all low.
- R3: In Idle, `cpu_clk_en` is low while `per_clk_en` and `posc_en` stay high.
- R4: Either low-power state is left when `irq_pend` or `wdt_timeout` is high at a clock edge.
- R5: On Sleep entry, `wdt_clr` is high for exactly one cycle if `wdt_en` is high, and stays low otherwise. `wdt_clr` is never high outside a Sleep entry.
- R6: `lprc_en` is high outside Sleep. During Sleep it equals `wdt_en`.
- R7: `fscm_dis` is high for the whole of Sleep and of the settling period that follows, and low otherwise.
- R8: `clk_src` does not change during Sleep or settling. After wake it holds the source that was active at Sleep entry.
- R9: A clock-source request (`osc_req` with `osc_sel`) updates `clk_src` on the next edge only in the run state with `cfg_lock` low. Any other request is ignored.
- R10: After a wake from Sleep, `cpu_clk_en` stays low for `SETTLE_CYC` more cycles after the wake edge. After a wake from Idle, it is high in the cycle after the wake edge.
- R11: Reset (`rst_n` low, asynchronous) forces the run state from any state. It sets `clk_src` to `SRC_DEFAULT`, clears the settling counter and clears both flags.
- R12: `slept_flag` and `idled_flag` are set on entry to Sleep and Idle and hold until a `flag_clr` strobe clears them. A set in the same cycle as a clear wins.
- R13: A command that arrives while `irq_pend` is high is an immediate wake. The block stays in run, sets no flag and issues no watchdog clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Power-save command strobe |
| save_mode | input | 1 | Command operand: 0 Sleep, 1 Idle |
| irq_pend | input | 1 | Enabled interrupt request pending |
| wdt_timeout | input | 1 | Watchdog time-out |
| wdt_en | input | 1 | Watchdog enabled |
| cfg_lock | input | 1 | Clock configuration lock |
| osc_req | input | 1 | Clock-source change request strobe |
| osc_sel | input | SRC_W | Requested clock source |
| flag_clr | input | 1 | Software clear strobe for the status flags |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| posc_en | output | 1 | Primary oscillator enable |
| lprc_en | output | 1 | Low-power RC clock enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| fscm_dis | output | 1 | Clock-fail monitor disable |
| clk_src | output | SRC_W | Active clock source |
| slept_flag | output | 1 | Sticky: Sleep was entered |
| idled_flag | output | 1 | Sticky: Idle was entered |

## Verification
The bench counts the settling window exactly. A counter off by one would raise the CPU clock a cycle early or a cycle late, and a design that skips settling would raise it at once. It issues a command with an interrupt already pending, where a faulty design would drop into Sleep, set the flag and clear the watchdog. It tries clock-source requests with the lock high and during Idle; a design that ignores either condition would change `clk_src`. It also asserts reset in the middle of settling and then times a complete settling window again, which shows up a counter that keeps its stale count.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_IDLE   = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_SETTLE = 2'd3
  } pwr_state_e;

  localparam logic MODE_SLEEP = 1'b0;
  localparam logic MODE_IDLE  = 1'b1;

  // True when the count about to be left is the final settling cycle.
  function automatic logic settle_last(input int unsigned count, input int unsigned target);
    return (count + 1) >= target;
  endfunction

  // Next value of a sticky flag: a set beats a same-cycle clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer
  import pwr_mode_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);

  logic [CNT_W-1:0] count_q;

  assign done = run & settle_last(32'(count_q), SETTLE_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear || done) begin
      count_q <= '0;
    end else if (run) begin
      count_q <= count_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) < SETTLE_CYC) else $error("settle count out of range"); // R10

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       save_req,
  input  logic       save_mode,
  input  logic       irq_pend,
  input  logic       wdt_timeout,
  input  logic       wdt_en,
  input  logic       settle_done,
  output pwr_state_e state,
  output logic       enter_sleep,
  output logic       enter_idle,
  output logic       wake_sleep,
  output logic       wdt_clr
);

  pwr_state_e state_q, state_d;
  logic       wake_evt;
  logic       cmd_ok;
  logic       wdt_clr_q;

  assign wake_evt    = irq_pend | wdt_timeout;
  assign cmd_ok      = (state_q == PS_RUN) & save_req & ~irq_pend;
  assign enter_sleep = cmd_ok & (save_mode == MODE_SLEEP);
  assign enter_idle  = cmd_ok & (save_mode == MODE_IDLE);
  assign wake_sleep  = (state_q == PS_SLEEP) & wake_evt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (enter_sleep)     state_d = PS_SLEEP;
        else if (enter_idle) state_d = PS_IDLE;
      end
      PS_IDLE:   if (wake_evt)    state_d = PS_RUN;
      PS_SLEEP:  if (wake_evt)    state_d = PS_SETTLE;
      PS_SETTLE: if (settle_done) state_d = PS_RUN;
      default:                    state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_RUN;
      wdt_clr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wdt_clr_q <= enter_sleep & wdt_en;
    end
  end

  assign state   = state_q;
  assign wdt_clr = wdt_clr_q;

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sleep |=> state_q == PS_SETTLE) else $error("sleep wake lost"); // R4
  AST_WAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && wake_evt) |=> state_q == PS_RUN) else $error("idle wake lost"); // R4
  AST_WDT_CLR_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> (state_q == PS_SLEEP && $past(state_q) == PS_RUN && $past(wdt_en))) else $error("stray wdt clear"); // R5
  AST_PENDING_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && save_req && irq_pend) |=> state_q == PS_RUN) else $error("entered with irq pending"); // R13

endmodule

// File: rtl/pwr_clk_select.sv
module pwr_clk_select #(
  parameter int unsigned SRC_W = 3,
  parameter logic [SRC_W-1:0] SRC_DEFAULT = SRC_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_run,
  input  logic             osc_req,
  input  logic [SRC_W-1:0] osc_sel,
  input  logic             cfg_lock,
  input  logic             enter_sleep,
  input  logic             restore,
  output logic [SRC_W-1:0] clk_src
);

  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] saved_q;
  logic             accept;

  assign accept = in_run & osc_req & ~cfg_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_DEFAULT;
      saved_q <= SRC_DEFAULT;
    end else begin
      if (enter_sleep) saved_q <= src_q;
      if (restore)     src_q   <= saved_q;
      else if (accept) src_q   <= osc_sel;
    end
  end

  assign clk_src = src_q;

  AST_LOCK_HOLDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lock && !restore) |=> $stable(clk_src)) else $error("locked source changed"); // R9
  AST_NO_CHANGE_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && !restore) |=> $stable(clk_src)) else $error("source changed outside run"); // R9

endmodule

// File: rtl/pwr_status_flags.sv
module pwr_status_flags
  import pwr_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_sleep,
  input  logic set_idle,
  input  logic clr,
  output logic slept,
  output logic idled
);

  logic slept_q, idled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slept_q <= 1'b0;
      idled_q <= 1'b0;
    end else begin
      slept_q <= sticky_next(slept_q, set_sleep, clr);
      idled_q <= sticky_next(idled_q, set_idle, clr);
    end
  end

  assign slept = slept_q;
  assign idled = idled_q;

  AST_SLEPT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slept_q) |-> $past(set_sleep)) else $error("slept flag set spuriously"); // R12
  AST_SLEPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slept_q && !clr) |=> slept_q) else $error("slept flag lost"); // R12

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned SRC_W = 3,
  parameter logic [SRC_W-1:0] SRC_DEFAULT = SRC_W'(1),
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             save_mode,
  input  logic             irq_pend,
  input  logic             wdt_timeout,
  input  logic             wdt_en,
  input  logic             cfg_lock,
  input  logic             osc_req,
  input  logic [SRC_W-1:0] osc_sel,
  input  logic             flag_clr,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             posc_en,
  output logic             lprc_en,
  output logic             wdt_clr,
  output logic             fscm_dis,
  output logic [SRC_W-1:0] clk_src,
  output logic             slept_flag,
  output logic             idled_flag
);

  pwr_state_e state;
  logic       enter_sleep;
  logic       enter_idle;
  logic       wake_sleep;
  logic       settle_done;
  logic       in_sleep;
  logic       in_settle;

  pwr_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .save_mode   (save_mode),
    .irq_pend    (irq_pend),
    .wdt_timeout (wdt_timeout),
    .wdt_en      (wdt_en),
    .settle_done (settle_done),
    .state       (state),
    .enter_sleep (enter_sleep),
    .enter_idle  (enter_idle),
    .wake_sleep  (wake_sleep),
    .wdt_clr     (wdt_clr)
  );

  assign in_sleep  = (state == PS_SLEEP);
  assign in_settle = (state == PS_SETTLE);

  pwr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wake_sleep),
    .run   (in_settle),
    .done  (settle_done)
  );

  pwr_clk_select #(.SRC_W(SRC_W), .SRC_DEFAULT(SRC_DEFAULT)) u_clk_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_run      (state == PS_RUN),
    .osc_req     (osc_req),
    .osc_sel     (osc_sel),
    .cfg_lock    (cfg_lock),
    .enter_sleep (enter_sleep),
    .restore     (settle_done),
    .clk_src     (clk_src)
  );

  pwr_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_sleep (enter_sleep),
    .set_idle  (enter_idle),
    .clr       (flag_clr),
    .slept     (slept_flag),
    .idled     (idled_flag)
  );

  assign cpu_clk_en = (state == PS_RUN);
  assign per_clk_en = (state == PS_RUN) | (state == PS_IDLE);
  assign posc_en    = ~in_sleep;
  assign lprc_en    = ~in_sleep | wdt_en;
  assign fscm_dis   = in_sleep | in_settle;

  AST_SLEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !posc_en |-> (!cpu_clk_en && !per_clk_en)) else $error("clock on in sleep"); // R2
  AST_IDLE_PER_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !fscm_dis) |-> (per_clk_en && posc_en)) else $error("idle gating"); // R3
  AST_LPRC_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !posc_en |-> (lprc_en == wdt_en)) else $error("lprc enable in sleep"); // R6
  AST_MONITOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fscm_dis |-> !cpu_clk_en) else $error("monitor off while running"); // R7
  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fscm_dis && $past(fscm_dis)) |-> $stable(clk_src)) else $error("source moved in sleep"); // R8
  AST_SETTLE_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(fscm_dis)) |-> $past(settle_done)) else $error("cpu clock before settle"); // R10

endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

  localparam int unsigned SRC_W = 3;
  localparam logic [SRC_W-1:0] SRC_DEF = 3'd1;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 0, save_mode = 0, irq_pend = 0, wdt_timeout = 0;
  logic wdt_en = 1, cfg_lock = 0, osc_req = 0, flag_clr = 0;
  logic [SRC_W-1:0] osc_sel = '0;
  logic cpu_clk_en, per_clk_en, posc_en, lprc_en, wdt_clr, fscm_dis;
  logic [SRC_W-1:0] clk_src;
  logic slept_flag, idled_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.SRC_W(SRC_W), .SRC_DEFAULT(SRC_DEF), .SETTLE_CYC(N)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_mode(save_mode),
    .irq_pend(irq_pend), .wdt_timeout(wdt_timeout), .wdt_en(wdt_en),
    .cfg_lock(cfg_lock), .osc_req(osc_req), .osc_sel(osc_sel), .flag_clr(flag_clr),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .posc_en(posc_en),
    .lprc_en(lprc_en), .wdt_clr(wdt_clr), .fscm_dis(fscm_dis), .clk_src(clk_src),
    .slept_flag(slept_flag), .idled_flag(idled_flag)
  );

  // {cfg_lock, osc_sel, expected clk_src}, applied in order from the default source
  localparam logic [6:0] SRC_VEC [6] = '{
    {1'b0, 3'd5, 3'd5},
    {1'b1, 3'd2, 3'd5},
    {1'b0, 3'd2, 3'd2},
    {1'b1, 3'd7, 3'd2},
    {1'b0, 3'd0, 3'd0},
    {1'b0, 3'd6, 3'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic command(input logic mode);
    save_req = 1; save_mode = mode;
    step();
    save_req = 0;
  endtask

  task automatic pulse_irq();
    irq_pend = 1; step(); irq_pend = 0;
  endtask

  task automatic pulse_wdt();
    wdt_timeout = 1; step(); wdt_timeout = 0;
  endtask

  task automatic clear_flags();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    step();
    // R11 reset state
    chk("R11 cpu_clk_en in reset", cpu_clk_en, 1);
    chk("R11 clk_src default", clk_src, SRC_DEF);
    chk("R11 flags clear", {slept_flag, idled_flag}, 0);
    chk("R7 monitor enabled in run", fscm_dis, 0);
    rst_n = 1;
    step();

    // R9 vector table of clock-source requests
    for (int i = 0; i < 6; i++) begin
      cfg_lock = SRC_VEC[i][6]; osc_sel = SRC_VEC[i][5:3]; osc_req = 1;
      step();
      osc_req = 0; cfg_lock = 0;
      chk($sformatf("R9 source vector %0d", i), clk_src, SRC_VEC[i][2:0]);
    end

    // R1 R2 R5 R6 R7 R12 sleep entry with watchdog enabled
    wdt_en = 1;
    command(1'b0);
    chk("R2 cpu off in sleep", cpu_clk_en, 0);
    chk("R2 per off in sleep", per_clk_en, 0);
    chk("R2 posc off in sleep", posc_en, 0);
    chk("R7 monitor disabled in sleep", fscm_dis, 1);
    chk("R5 wdt clear pulse", wdt_clr, 1);
    chk("R6 lprc on with wdt", lprc_en, 1);
    chk("R12 slept flag set", slept_flag, 1);
    // R9 request during sleep ignored
    osc_req = 1; osc_sel = 3'd3;
    step();
    osc_req = 0;
    chk("R5 wdt clear one cycle", wdt_clr, 0);
    chk("R1 save_req in sleep ignored", {cpu_clk_en, per_clk_en}, 0);
    chk("R8 source held in sleep", clk_src, 3'd6);

    // R4 R10 wake by interrupt, full settle count
    pulse_irq();
    chk("R10 cpu off at settle start", cpu_clk_en, 0);
    chk("R7 monitor disabled in settle", fscm_dis, 1);
    for (int k = 0; k < int'(N) - 1; k++) begin
      step();
      chk($sformatf("R10 cpu still off settle %0d", k), cpu_clk_en, 0);
    end
    step();
    chk("R10 cpu on after settle", cpu_clk_en, 1);
    chk("R7 monitor back after settle", fscm_dis, 0);
    chk("R8 source restored", clk_src, 3'd6);
    chk("R4 per on after wake", per_clk_en, 1);

    // R3 R4 R10 idle, wake by watchdog time-out
    command(1'b1);
    chk("R3 cpu off in idle", cpu_clk_en, 0);
    chk("R3 per on in idle", per_clk_en, 1);
    chk("R3 posc on in idle", posc_en, 1);
    chk("R12 idled flag set", idled_flag, 1);
    cfg_lock = 0; osc_req = 1; osc_sel = 3'd4;
    step();
    osc_req = 0;
    chk("R9 request in idle ignored", clk_src, 3'd6);
    pulse_wdt();
    chk("R10 idle wake next cycle", cpu_clk_en, 1);

    // R12 clear, and set beats clear
    clear_flags();
    chk("R12 flags cleared", {slept_flag, idled_flag}, 0);
    flag_clr = 1; save_req = 1; save_mode = 1'b1;
    step();
    flag_clr = 0; save_req = 0;
    chk("R12 set wins over clear", idled_flag, 1);
    pulse_irq();
    clear_flags();

    // R13 command with interrupt already pending
    irq_pend = 1;
    command(1'b0);
    irq_pend = 0;
    chk("R13 stays in run", cpu_clk_en, 1);
    chk("R13 no wdt clear", wdt_clr, 0);
    chk("R13 no flag", slept_flag, 0);

    // R5 R6 sleep with watchdog disabled, wake by time-out
    wdt_en = 0;
    command(1'b0);
    chk("R5 no clear with wdt off", wdt_clr, 0);
    chk("R6 lprc off in sleep with wdt off", lprc_en, 0);
    pulse_wdt();
    chk("R6 lprc on once out of sleep", lprc_en, 1);
    chk("R4 wdt timeout wakes sleep", fscm_dis, 1);
    // R11 reset in mid-settle
    step(); step();
    rst_n = 0;
    step();
    chk("R11 reset forces run", cpu_clk_en, 1);
    chk("R11 reset restores default source", clk_src, SRC_DEF);
    chk("R11 reset clears flags", slept_flag, 0);
    rst_n = 1; wdt_en = 1;
    step();
    // R11 counter cleared: a fresh sleep needs the full window again
    command(1'b0);
    pulse_irq();
    for (int k = 0; k < int'(N) - 1; k++) step();
    chk("R11 settle full length after reset", cpu_clk_en, 0);
    step();
    chk("R11 settle ends on count", cpu_clk_en, 1);

    done = 1;
    finish_run();
  end

endmodule